// File: doc/BRIEF.md
# Processor Status Register Flag Unit

This block keeps the 16-bit status word of a processor core. The lower byte carries five condition flags (extend, negative, zero, overflow, carry). The ALU refreshes them after each operation from the operands, the result and the adder carry, all taken at one of three operand sizes. The upper byte is the system byte. It holds two trace-enable bits, the supervisor bit and a three-bit interrupt priority mask. The block also accepts a full write of the register and applies a privilege rule: in user mode only the flag byte can change.

Two status outputs are decoded from the live register. One says whether an interrupt at the presented level would be taken; level 7 is always taken. The other raises a trace request when an instruction completes while either trace bit is set. Stack-pointer selection and exception sequencing are handled elsewhere in the core.

Top module: `psr_unit`

## Requirements
- R1: After reset, `sr` reads 16'h2700: supervisor set, mask 7, both trace bits clear, all flags clear.
- R2: Bit positions are C=0, V=1, Z=2, N=3, X=4, mask=10:8, S=13, T0=14, T1=15. Bits 12, 11 and 7:5 always read 0, whatever is written.
- R3: On a flag update, N takes the top bit of the result at the selected size and Z is 1 only if all result bits of that size are 0. Size code 0 is 8 bits, 1 is 16 bits, and 2 or 3 is 32 bits.
- R4: V is 1 when a signed add (class 0) or subtract (class 1, result = a - b) does not fit in the operand size.
- R5: For add, C equals `alu_cout`. For subtract, `alu_cout` is the adder carry of a + ~b + 1, and C is its inverse (a borrow).
- R6: After add or subtract, X takes the new C value. Logic (class 2) and move (class 3) updates leave X unchanged.
- R7: Logic and move updates clear V and C.
- R8: A register write in supervisor mode loads every defined bit. In user mode (S=0) it loads only the flag byte, and the system byte keeps its value.
- R9: When `wr_en` and `alu_valid` arrive in the same cycle, the register write is applied and the flag update is dropped.
- R10: `irq_accept` is 1 when `irq_level` is greater than the mask, or when `irq_level` is 7. Level 0 is never taken below mask 7.
- R11: `trace_pend` is 1 in a cycle with `insn_done` high while T1 or T0 is set, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alu_valid | input | 1 | Flag update request for this cycle |
| alu_cls | input | 2 | Operation class: 0 add, 1 subtract, 2 logic, 3 move |
| alu_size | input | 2 | Operand size: 0 byte, 1 word, 2/3 long |
| opnd_a | input | DATA_W | First operand |
| opnd_b | input | DATA_W | Second operand |
| alu_res | input | DATA_W | ALU result |
| alu_cout | input | 1 | Adder carry out of the top bit at the selected size |
| wr_en | input | 1 | Whole-register write request |
| wr_data | input | 16 | Value to write |
| insn_done | input | 1 | Instruction completion strobe |
| irq_level | input | 3 | Priority of the pending interrupt request (0 = none) |
| sr | output | 16 | Status register value |
| supervisor | output | 1 | Current supervisor bit |
| ipl_mask | output | 3 | Current interrupt mask |
| trace_pend | output | 1 | Trace request for the completing instruction |
| irq_accept | output | 1 | Presented interrupt level would be accepted |

## Verification
Flag updates and register writes are sampled on a rising edge and show in `sr`, `supervisor` and `ipl_mask` right after that edge. The scoreboard therefore pushes the expected word once the edge that consumed the request has passed, and the monitor compares it at the following falling edge. `irq_accept` and `trace_pend` are decoded from the current register and the present inputs in the same cycle. They are checked a short delay after their inputs change, and the register state they depend on is settled by earlier scoreboard items. Corner cases include byte operations whose upper result bits are non-zero, signed overflow in both directions, borrow on subtract, a user-mode write attempt, and a write colliding with a flag update.

// File: rtl/psr_pkg.sv
package psr_pkg;
    localparam int SR_W  = 16;
    localparam int IPL_W = 3;

    typedef enum logic [1:0] {
        CLS_ADD   = 2'd0,
        CLS_SUB   = 2'd1,
        CLS_LOGIC = 2'd2,
        CLS_MOVE  = 2'd3
    } alu_cls_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_LALT = 2'd3
    } opsz_e;

    typedef struct packed {
        logic x;
        logic n;
        logic z;
        logic v;
        logic c;
    } ccr_t;

    typedef struct packed {
        logic [1:0]       trc;
        logic             sup;
        logic [IPL_W-1:0] ipl;
    } sysb_t;

    localparam sysb_t SYS_RESET = '{trc: 2'b00, sup: 1'b1, ipl: 3'b111};

    function automatic logic [SR_W-1:0] sr_pack(sysb_t s, ccr_t c);
        return {s.trc, s.sup, 2'b00, s.ipl, 3'b000, c};
    endfunction

    function automatic sysb_t sys_from(logic [SR_W-1:0] w);
        sysb_t s;
        s.trc = w[15:14];
        s.sup = w[13];
        s.ipl = w[10:8];
        return s;
    endfunction

    function automatic ccr_t ccr_from(logic [SR_W-1:0] w);
        return ccr_t'(w[4:0]);
    endfunction

    function automatic logic is_arith(alu_cls_e k);
        return (k == CLS_ADD) || (k == CLS_SUB);
    endfunction
endpackage

// File: rtl/psr_ccr_eval.sv
module psr_ccr_eval
    import psr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  alu_cls_e          cls,
    input  opsz_e             size,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [DATA_W-1:0] r,
    input  logic              cout,
    input  logic              x_prev,
    output ccr_t              flags
);
    localparam int BYTE_W = DATA_W / 4;
    localparam int N_SZ   = 3;

    logic [N_SZ-1:0] a_top_v, b_top_v, r_top_v, r_zero_v;

    generate
        for (genvar g = 0; g < N_SZ; g++) begin : g_size
            localparam int W = BYTE_W << g;
            assign a_top_v[g]  = a[W-1];
            assign b_top_v[g]  = b[W-1];
            assign r_top_v[g]  = r[W-1];
            assign r_zero_v[g] = ~|r[W-1:0];
        end
    endgenerate

    logic unused_opnd;
    assign unused_opnd = ^{a, b};

    logic [1:0] sel;
    always_comb begin
        case (size)
            SZ_BYTE: sel = 2'd0;
            SZ_WORD: sel = 2'd1;
            default: sel = 2'd2;
        endcase
    end

    logic a_top, b_top, r_top;
    assign a_top = a_top_v[sel];
    assign b_top = b_top_v[sel];
    assign r_top = r_top_v[sel];

    always_comb begin
        flags.n = r_top;
        flags.z = r_zero_v[sel];
        case (cls)
            CLS_ADD: begin
                flags.v = (a_top == b_top) && (r_top != a_top);
                flags.c = cout;
            end
            CLS_SUB: begin
                flags.v = (a_top != b_top) && (r_top != a_top);
                flags.c = ~cout;
            end
            default: begin
                flags.v = 1'b0;
                flags.c = 1'b0;
            end
        endcase
        flags.x = is_arith(cls) ? flags.c : x_prev;
    end
endmodule

// File: rtl/psr_irq_gate.sv
module psr_irq_gate #(
    parameter int IPL_W = 3
) (
    input  logic [IPL_W-1:0] level,
    input  logic [IPL_W-1:0] mask,
    output logic             accept
);
    logic nmi;
    assign nmi    = &level;
    assign accept = nmi | (level > mask);
endmodule

// File: rtl/psr_unit.sv
module psr_unit
    import psr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alu_valid,
    input  logic [1:0]        alu_cls,
    input  logic [1:0]        alu_size,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [DATA_W-1:0] alu_res,
    input  logic              alu_cout,
    input  logic              wr_en,
    input  logic [15:0]       wr_data,
    input  logic              insn_done,
    input  logic [2:0]        irq_level,
    output logic [15:0]       sr,
    output logic              supervisor,
    output logic [2:0]        ipl_mask,
    output logic              trace_pend,
    output logic              irq_accept
);
    sysb_t sys_q;
    ccr_t  ccr_q;
    ccr_t  ccr_new;

    psr_ccr_eval #(.DATA_W(DATA_W)) u_ccr (
        .cls    (alu_cls_e'(alu_cls)),
        .size   (opsz_e'(alu_size)),
        .a      (opnd_a),
        .b      (opnd_b),
        .r      (alu_res),
        .cout   (alu_cout),
        .x_prev (ccr_q.x),
        .flags  (ccr_new)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sys_q <= SYS_RESET;
            ccr_q <= '0;
        end else if (wr_en) begin
            ccr_q <= ccr_from(wr_data);
            if (sys_q.sup) begin
                sys_q <= sys_from(wr_data);
            end
        end else if (alu_valid) begin
            ccr_q <= ccr_new;
        end
    end

    psr_irq_gate #(.IPL_W(IPL_W)) u_irq (
        .level  (irq_level),
        .mask   (sys_q.ipl),
        .accept (irq_accept)
    );

    assign sr         = sr_pack(sys_q, ccr_q);
    assign supervisor = sys_q.sup;
    assign ipl_mask   = sys_q.ipl;
    assign trace_pend = insn_done & (|sys_q.trc);

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (sr == 16'h2700 && supervisor && ipl_mask == 3'd7)); // R1
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (sr[12:11] == 2'b00 && sr[7:5] == 3'b000)); // R2
    AST_NZ_EXCL: assert property (@(posedge clk) disable iff (rst)
        (alu_valid && !wr_en) |=> !(sr[3] && sr[2])); // R3
    AST_X_KEEP: assert property (@(posedge clk) disable iff (rst)
        (alu_valid && !wr_en && alu_cls[1]) |=> $stable(sr[4])); // R6
    AST_VC_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (alu_valid && !wr_en && alu_cls[1]) |=> (sr[1:0] == 2'b00)); // R7
    AST_USER_LOCK: assert property (@(posedge clk) disable iff (rst)
        !supervisor |=> ($stable(sr[15:8]) && !supervisor)); // R8
    AST_WR_PRIO: assert property (@(posedge clk) disable iff (rst)
        (wr_en && supervisor) |=> (sr == ($past(wr_data) & 16'hE71F))); // R9
    AST_NMI_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (irq_level == 3'd7) |-> irq_accept); // R10
    AST_TRACE_REQ: assert property (@(posedge clk) disable iff (rst)
        (insn_done && sr[15:14] != 2'b00) |-> trace_pend); // R11
endmodule

// File: tb/psr_unit_tb_top.sv
`timescale 1ns/1ps
module psr_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        alu_valid = 1'b0;
    logic [1:0]  alu_cls = '0;
    logic [1:0]  alu_size = '0;
    logic [31:0] opnd_a = '0, opnd_b = '0, alu_res = '0;
    logic        alu_cout = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        insn_done = 1'b0;
    logic [2:0]  irq_level = '0;
    logic [15:0] sr;
    logic        supervisor, trace_pend, irq_accept;
    logic [2:0]  ipl_mask;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [15:0] exp_q[$];
    string       tag_q[$];
    logic [15:0] ref_sr;

    always #4 clk = ~clk;

    psr_unit #(.DATA_W(32)) dut_i (
        .clk(clk), .rst(rst), .alu_valid(alu_valid), .alu_cls(alu_cls),
        .alu_size(alu_size), .opnd_a(opnd_a), .opnd_b(opnd_b), .alu_res(alu_res),
        .alu_cout(alu_cout), .wr_en(wr_en), .wr_data(wr_data), .insn_done(insn_done),
        .irq_level(irq_level), .sr(sr), .supervisor(supervisor), .ipl_mask(ipl_mask),
        .trace_pend(trace_pend), .irq_accept(irq_accept)
    );

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [4:0] ref_ccr(int cls, int sz, logic [31:0] a, logic [31:0] b,
                                           logic [31:0] r, logic cout, logic xold);
        int w = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
        logic [31:0] m = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
        logic n = r[w-1];
        logic z = ((r & m) == 32'd0);
        logic an = a[w-1];
        logic bn = b[w-1];
        logic v = 1'b0, c = 1'b0, x = xold;
        if (cls == 0) begin
            c = cout;
            v = (an & bn & ~n) | (~an & ~bn & n);
            x = c;
        end else if (cls == 1) begin
            c = ~cout;
            v = (an & ~bn & ~n) | (~an & bn & n);
            x = c;
        end
        return {x, n, z, v, c};
    endfunction

    function automatic logic [15:0] ref_write(logic [15:0] cur, logic [15:0] w);
        if (cur[13]) return w & 16'hE71F;
        return {cur[15:8], w[7:0] & 8'h1F};
    endfunction

    // driver: applies one flag update, then queues the expected register word
    task automatic do_alu(string tag, int cls, int sz, logic [31:0] a, logic [31:0] b,
                          logic [31:0] r, logic cout);
        @(negedge clk);
        alu_valid = 1'b1; alu_cls = cls[1:0]; alu_size = sz[1:0];
        opnd_a = a; opnd_b = b; alu_res = r; alu_cout = cout;
        @(posedge clk);
        #1;
        alu_valid = 1'b0;
        ref_sr = {ref_sr[15:5], ref_ccr(cls, sz, a, b, r, cout, ref_sr[4])};
        exp_q.push_back(ref_sr);
        tag_q.push_back(tag);
    endtask

    task automatic do_write(string tag, logic [15:0] w, bit with_alu);
        @(negedge clk);
        wr_en = 1'b1; wr_data = w;
        if (with_alu) begin
            alu_valid = 1'b1; alu_cls = 2'd0; alu_size = 2'd0;
            opnd_a = 32'hFF; opnd_b = 32'h1; alu_res = 32'h0; alu_cout = 1'b1;
        end
        @(posedge clk);
        #1;
        wr_en = 1'b0; alu_valid = 1'b0;
        ref_sr = ref_write(ref_sr, w);
        exp_q.push_back(ref_sr);
        tag_q.push_back(tag);
    endtask

    // monitor: compares queued expectations one cycle behind the driver
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                logic [15:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, sr, e);
            end
        end
    end

    task automatic drain();
        repeat (3) @(negedge clk);
    endtask

    task automatic chk_irq(string tag, logic [2:0] lvl, logic exp);
        @(negedge clk);
        irq_level = lvl;
        #1;
        check(tag, {15'd0, irq_accept}, {15'd0, exp});
        irq_level = 3'd0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        ref_sr = 16'h2700;
        @(negedge clk);
        check("R1 reset sr", sr, 16'h2700);
        check("R1 reset supervisor/mask", {12'd0, supervisor, ipl_mask}, 16'h000F);
        check("R1 reset trace idle", {15'd0, trace_pend}, 16'h0);

        do_alu("R4 add byte overflow", 0, 0, 32'h7F, 32'h01, 32'h80, 1'b0);
        do_alu("R5 R6 add byte carry", 0, 0, 32'hFF, 32'h01, 32'h100, 1'b1);
        do_alu("R7 R6 logic long keeps X", 2, 2, 32'h0, 32'h0, 32'h8000_0000, 1'b1);
        do_alu("R5 sub word borrow", 1, 1, 32'h0, 32'h1, 32'hFFFF, 1'b0);
        do_alu("R4 sub word overflow", 1, 1, 32'h8000, 32'h1, 32'h7FFF, 1'b1);
        do_alu("R3 move byte zero at size", 3, 0, 32'h0, 32'h0, 32'h1200, 1'b0);
        do_alu("R4 add long overflow", 0, 2, 32'h7FFF_FFFF, 32'h1, 32'h8000_0000, 1'b0);
        do_alu("R3 size code 3 as long", 3, 3, 32'h0, 32'h0, 32'h0001_0000, 1'b0);
        drain();

        do_write("R2 R8 supervisor write", 16'hFFFF, 1'b0);
        drain();
        @(negedge clk);
        insn_done = 1'b1;
        #1;
        check("R11 trace pending", {15'd0, trace_pend}, 16'h1);
        insn_done = 1'b0;
        #1;
        check("R11 no completion", {15'd0, trace_pend}, 16'h0);
        chk_irq("R10 level 6 under mask 7", 3'd6, 1'b0);
        chk_irq("R10 level 7 non-maskable", 3'd7, 1'b1);

        do_write("R9 write beats update", 16'h2305, 1'b1);
        drain();
        chk_irq("R10 level equal mask", 3'd3, 1'b0);
        chk_irq("R10 level above mask", 3'd4, 1'b1);
        @(negedge clk);
        insn_done = 1'b1;
        #1;
        check("R11 trace clear", {15'd0, trace_pend}, 16'h0);
        insn_done = 1'b0;

        do_write("R8 enter user mode", 16'h0001, 1'b0);
        drain();
        chk_irq("R10 level 0 mask 0", 3'd0, 1'b0);
        do_write("R8 user write system byte ignored", 16'hE71E, 1'b0);
        drain();
        check("R8 user mask kept", {12'd0, supervisor, ipl_mask}, 16'h0000);
        do_alu("R6 sub sets X in user mode", 1, 0, 32'h5, 32'h3, 32'h2, 1'b1);
        drain();
        finish_run();
    end
endmodule